// File: doc/BRIEF.md
# External Interrupt Line Controller

This block collects a parameterised number of external interrupt lines, up to 32, and merges them into a single interrupt request for the processor. Each line first passes through a two-stage synchroniser. It is then sensed according to its own configuration: a falling edge, a rising edge, a low level or a high level. The result is held in a per-line status bit. A per-line mask bit decides whether that status bit reaches the combined request output.

Software uses a small word-addressed register bus with a write strobe and a combinational read port. Mask bits are never written directly. One address sets the mask bits selected by ones in the written word, and another address clears them, so two agents can change different lines without a read-modify-write. A third address clears latched status bits in the same write-one style. Sense configuration is held in three bitmaps: one picks edge or level, one picks the edge polarity and one picks the level polarity. Bits above the implemented line count always read back as zero. Software can therefore write all ones to the mode bitmap and read it back to find how many lines exist.

Top module: `xirq_ctrl`

## Requirements
- R1: A write to address 0 sets every mask bit whose data bit is 1. Data bits of 0 leave the matching mask bits unchanged. The mask reads back at address 2.
- R2: A write to address 1 clears every mask bit whose data bit is 1. Data bits of 0 leave the matching mask bits unchanged.
- R3: A write to address 3 clears the latched status bit of each edge-sensed line whose data bit is 1. Data bits of 0 have no effect. Status reads back at address 4.
- R4: The sense bitmaps are read/write: mode at address 5, edge polarity at address 6 and level polarity at address 7. A line with mode bit 0 is edge-sensed. With edge bit 1 it latches status on a rising edge of the synchronised input; with edge bit 0 it latches on a falling edge. Status then stays set until it is cleared.
- R5: When a selected edge is detected on the same clock edge that a clear write for that line takes effect, the status bit stays set.
- R6: A line with mode bit 1 is level-sensed. Its status follows the synchronised input being at the active level: high when the level bit is 1, low when it is 0. A clear write while the level is still active leaves the status bit at 1.
- R7: Bits at and above NUM_LINES read as zero at every address, whatever was written. After all ones are written to the mode bitmap, it reads back as 2^NUM_LINES-1.
- R8: The irq_o output is 1 exactly when some line has both its status bit and its mask bit at 1.
- R9: After reset, all mask, status and sense bits are zero, irq_o is 0, and every address, including the write-only addresses 0, 1 and 3, reads zero.
- R10: A change on an input line first shows in the status bit after the third rising clock edge following the change, never after the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | REG_W | Write data |
| bus_rdata | output | REG_W | Read data for bus_addr (combinational) |
| ext_in | input | NUM_LINES | Asynchronous external interrupt lines |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Each line is driven through all four sense settings in turn, with only that line active. The status word is sampled after two and after three clock edges. This separates the four sense types from each other and from neighbouring lines, and confirms the synchroniser latency. Edge lines are then returned to idle to show that status is held, while level lines are cleared while still active to show that a clear cannot override the level. The combined request is compared against every pairing of a 6-bit level-driven status pattern with a 6-bit mask pattern. This catches any line that is dropped from the reduction or left out of the masking. A clear that lands on the same edge as a fresh edge separates set-priority from clear-priority.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        ADR_ENA_SET  = 3'd0,
        ADR_ENA_CLR  = 3'd1,
        ADR_MASK     = 3'd2,
        ADR_STAT_CLR = 3'd3,
        ADR_STAT     = 3'd4,
        ADR_MODE     = 3'd5,
        ADR_EDGE     = 3'd6,
        ADR_LEVEL    = 3'd7
    } xirq_addr_e;

    typedef enum logic [1:0] {
        SENSE_FALL = 2'd0,
        SENSE_RISE = 2'd1,
        SENSE_LOW  = 2'd2,
        SENSE_HIGH = 2'd3
    } sense_e;

    typedef struct packed {
        logic ena_set;
        logic ena_clr;
        logic stat_clr;
        logic mode_wr;
        logic edge_wr;
        logic lvl_wr;
    } wr_strobe_t;

    function automatic sense_e sense_of(input logic mode_b, input logic edge_b,
                                        input logic lvl_b);
        if (mode_b) return lvl_b ? SENSE_HIGH : SENSE_LOW;
        return edge_b ? SENSE_RISE : SENSE_FALL;
    endfunction

    function automatic wr_strobe_t decode_wr(input logic we, input logic [ADDR_W-1:0] a);
        wr_strobe_t s;
        s = '0;
        if (we) begin
            case (xirq_addr_e'(a))
                ADR_ENA_SET:  s.ena_set  = 1'b1;
                ADR_ENA_CLR:  s.ena_clr  = 1'b1;
                ADR_STAT_CLR: s.stat_clr = 1'b1;
                ADR_MODE:     s.mode_wr  = 1'b1;
                ADR_EDGE:     s.edge_wr  = 1'b1;
                ADR_LEVEL:    s.lvl_wr   = 1'b1;
                default:      s = '0;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= async_in;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[s] <= '0;
            else     chain[s] <= chain[s-1];
        end
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/xirq_sense.sv
module xirq_sense
    import xirq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic smp,
    input  logic mode_b,
    input  logic edge_b,
    input  logic lvl_b,
    input  logic clr,
    output logic stat
);
    logic   prev_q;
    logic   stat_q;
    logic   rise;
    logic   fall;
    logic   stat_n;
    sense_e kind;

    assign kind = sense_of(mode_b, edge_b, lvl_b);
    assign rise = smp & ~prev_q;
    assign fall = ~smp & prev_q;

    always_comb begin
        unique case (kind)
            SENSE_RISE: stat_n = rise | (stat_q & ~clr);
            SENSE_FALL: stat_n = fall | (stat_q & ~clr);
            SENSE_HIGH: stat_n = smp;
            SENSE_LOW:  stat_n = ~smp;
            default:    stat_n = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            stat_q <= 1'b0;
        end else begin
            prev_q <= smp;
            stat_q <= stat_n;
        end
    end

    assign stat = stat_q;
endmodule

// File: rtl/xirq_regs.sv
module xirq_regs
    import xirq_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int REG_W     = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [REG_W-1:0]     bus_wdata,
    input  logic [NUM_LINES-1:0] stat,
    output logic [REG_W-1:0]     bus_rdata,
    output logic [NUM_LINES-1:0] mask,
    output logic [NUM_LINES-1:0] mode,
    output logic [NUM_LINES-1:0] edg,
    output logic [NUM_LINES-1:0] lvl,
    output logic [NUM_LINES-1:0] stat_clr
);
    wr_strobe_t           stb;
    logic [NUM_LINES-1:0] wd;
    logic [NUM_LINES-1:0] mask_q, mode_q, edge_q, lvl_q;
    logic                 unused_wdata;

    assign stb          = decode_wr(bus_we, bus_addr);
    assign wd           = bus_wdata[NUM_LINES-1:0];
    assign unused_wdata = ^bus_wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            mode_q <= '0;
            edge_q <= '0;
            lvl_q  <= '0;
        end else begin
            if (stb.ena_set) mask_q <= mask_q | wd;
            if (stb.ena_clr) mask_q <= mask_q & ~wd;
            if (stb.mode_wr) mode_q <= wd;
            if (stb.edge_wr) edge_q <= wd;
            if (stb.lvl_wr)  lvl_q  <= wd;
        end
    end

    assign stat_clr = stb.stat_clr ? wd : '0;

    always_comb begin
        bus_rdata = '0;
        case (xirq_addr_e'(bus_addr))
            ADR_MASK:  bus_rdata = REG_W'(mask_q);
            ADR_STAT:  bus_rdata = REG_W'(stat);
            ADR_MODE:  bus_rdata = REG_W'(mode_q);
            ADR_EDGE:  bus_rdata = REG_W'(edge_q);
            ADR_LEVEL: bus_rdata = REG_W'(lvl_q);
            default:   bus_rdata = '0;
        endcase
    end

    assign mask = mask_q;
    assign mode = mode_q;
    assign edg  = edge_q;
    assign lvl  = lvl_q;
endmodule

// File: rtl/xirq_ctrl.sv
module xirq_ctrl
    import xirq_pkg::*;
#(
    parameter int NUM_LINES   = 8,
    parameter int REG_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_we,
    input  logic [2:0]           bus_addr,
    input  logic [REG_W-1:0]     bus_wdata,
    output logic [REG_W-1:0]     bus_rdata,
    input  logic [NUM_LINES-1:0] ext_in,
    output logic                 irq_o
);
    logic [NUM_LINES-1:0] smp;
    logic [NUM_LINES-1:0] mask_q, mode_q, edge_q, lvl_q;
    logic [NUM_LINES-1:0] stat_clr;
    logic [NUM_LINES-1:0] stat_q;

    xirq_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .async_in(ext_in), .sync_out(smp)
    );

    xirq_regs #(.NUM_LINES(NUM_LINES), .REG_W(REG_W)) u_regs (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .stat(stat_q), .bus_rdata(bus_rdata),
        .mask(mask_q), .mode(mode_q), .edg(edge_q), .lvl(lvl_q),
        .stat_clr(stat_clr)
    );

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        xirq_sense u_sense (
            .clk(clk), .rst(rst), .smp(smp[i]), .mode_b(mode_q[i]),
            .edge_b(edge_q[i]), .lvl_b(lvl_q[i]), .clr(stat_clr[i]),
            .stat(stat_q[i])
        );
    end

    assign irq_o = |(stat_q & mask_q);
endmodule

// File: rtl/xirq_chk.sv
module xirq_chk
    import xirq_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int REG_W     = 32
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 bus_we,
    input logic [2:0]           bus_addr,
    input logic [REG_W-1:0]     bus_wdata,
    input logic                 irq,
    input logic [NUM_LINES-1:0] mask,
    input logic [NUM_LINES-1:0] stat,
    input logic [NUM_LINES-1:0] mode
);
    logic [NUM_LINES-1:0] wd;
    logic [NUM_LINES-1:0] clr_vec;
    logic                 set_wr, clr_wr;
    logic                 unused_hi;

    assign wd        = bus_wdata[NUM_LINES-1:0];
    assign unused_hi = ^bus_wdata;
    assign set_wr    = bus_we && (bus_addr == ADR_ENA_SET);
    assign clr_wr    = bus_we && (bus_addr == ADR_ENA_CLR);
    assign clr_vec   = (bus_we && (bus_addr == ADR_STAT_CLR)) ? wd : '0;

    p_set_mask_r1: assert property (@(posedge clk) disable iff (rst)
        set_wr |=> ((mask & $past(wd)) == $past(wd)));

    p_mask_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !(set_wr || clr_wr) |=> $stable(mask));

    p_clr_mask_r2: assert property (@(posedge clk) disable iff (rst)
        clr_wr |=> ((mask & $past(wd)) == '0));

    p_edge_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(stat & ~mode & ~clr_vec) & ~stat) == '0));

    p_irq_src_r8: assert property (@(posedge clk) disable iff (rst)
        irq |-> ((stat & mask) != '0));

    p_reset_zero_r9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mask == '0 && stat == '0 && mode == '0 && !irq));
endmodule

bind xirq_ctrl xirq_chk #(.NUM_LINES(NUM_LINES), .REG_W(REG_W)) u_chk (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .irq(irq_o), .mask(mask_q), .stat(stat_q),
    .mode(mode_q)
);

// File: tb/sim_xirq_ctrl.sv
module sim_xirq_ctrl;
    localparam int N = 6;
    localparam int W = 32;
    localparam logic [W-1:0] ALL  = '1;
    localparam logic [W-1:0] FULL = (W'(1) << N) - 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         bus_we = 1'b0;
    logic [2:0]   bus_addr = '0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic [N-1:0] ext_in = '0;
    logic         irq_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    xirq_ctrl #(.NUM_LINES(N), .REG_W(W)) u0 (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_in(ext_in),
        .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [W-1:0] r;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R9: reset state at every address
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), r);
            check("R9 reset read", r, '0);
        end
        check("R9 irq after reset", W'(irq_o), '0);

        // R1 / R2: write-one set and clear of mask
        wr(3'd0, 32'h05); wr(3'd0, 32'h00); rd(3'd2, r); check("R1 set", r, 32'h05);
        wr(3'd0, 32'h12); rd(3'd2, r); check("R1 set or", r, 32'h17);
        wr(3'd1, 32'h04); rd(3'd2, r); check("R2 clear", r, 32'h13);
        wr(3'd1, 32'h00); rd(3'd2, r); check("R2 zero write", r, 32'h13);

        // R7: unimplemented bits read zero
        wr(3'd5, ALL); rd(3'd5, r); check("R7 mode width", r, FULL);
        wr(3'd6, ALL); rd(3'd6, r); check("R7 edge width", r, FULL);
        wr(3'd7, ALL); rd(3'd7, r); check("R7 level width", r, FULL);
        wr(3'd0, ALL); rd(3'd2, r); check("R7 mask width", r, FULL);

        // R8: combined request over all status x mask patterns (all lines level-high)
        for (int s = 0; s < (1 << N); s++) begin
            for (int m = 0; m < (1 << N); m++) begin
                ext_in = N'(s);
                wr(3'd1, ALL);
                wr(3'd0, W'(m));
                rd(3'd4, r); check("R6 level status", r, W'(s));
                check("R8 irq", W'(irq_o), W'((s & m) != 0));
            end
        end
        rd(3'd4, r); check("R7 status width", r, FULL);

        // R4 / R6 / R10 / R3: per-line sweep over all four sense types
        for (int i = 0; i < N; i++) begin
            for (int t = 0; t < 4; t++) begin
                logic md, pol;
                md  = t[1];
                pol = t[0];
                wr(3'd1, ALL);
                ext_in = '0;
                ext_in[i] = ~pol;
                wr(3'd5, W'(md) << i);
                wr(3'd6, W'(pol) << i);
                wr(3'd7, W'(pol) << i);
                repeat (4) @(negedge clk);
                wr(3'd3, ALL);
                rd(3'd4, r); check("R4 R6 idle", r, '0);
                ext_in[i] = pol;
                repeat (2) @(negedge clk);
                rd(3'd4, r); check("R10 not after two edges", r, '0);
                @(negedge clk);
                rd(3'd4, r); check(md ? "R6 level active" : "R4 edge latched", r, W'(1) << i);
                check("R8 masked off", W'(irq_o), '0);
                if (!md) begin
                    ext_in[i] = ~pol;
                    repeat (4) @(negedge clk);
                    rd(3'd4, r); check("R4 sticky", r, W'(1) << i);
                    wr(3'd3, 32'h0);
                    rd(3'd4, r); check("R3 zero write", r, W'(1) << i);
                    wr(3'd3, W'(1) << i);
                    rd(3'd4, r); check("R3 clear", r, '0);
                end else begin
                    wr(3'd3, W'(1) << i);
                    rd(3'd4, r); check("R6 clear while active", r, W'(1) << i);
                    ext_in[i] = ~pol;
                    repeat (3) @(negedge clk);
                    rd(3'd4, r); check("R6 follows level", r, '0);
                end
            end
        end

        // R5: clear and new rising edge on the same clock edge
        wr(3'd5, 32'h0); wr(3'd6, 32'h1); wr(3'd7, 32'h0);
        ext_in = '0;
        repeat (4) @(negedge clk);
        wr(3'd3, ALL);
        ext_in[0] = 1'b1;
        repeat (3) @(negedge clk);
        rd(3'd4, r); check("R5 first edge", r, 32'h1);
        ext_in[0] = 1'b0;
        repeat (4) @(negedge clk);
        ext_in[0] = 1'b1;
        @(negedge clk);
        wr(3'd3, 32'h1);
        rd(3'd4, r); check("R5 edge beats clear", r, 32'h1);
        wr(3'd3, 32'h1);
        rd(3'd4, r); check("R3 clear without edge", r, '0);
        wr(3'd0, 32'h1);
        check("R8 no status no irq", W'(irq_o), '0);

        finish_run();
    end
endmodule